// File: doc/BRIEF.md
# Load-Linked Reservation Monitor

This block sits in front of a shared memory and keeps the reservation state that backs a load-linked / store-conditional pair for several requesting contexts. Every accepted request carries a context number, a physical address and a kind (plain read, load-linked, plain store or store-conditional). For each request the block returns whether a store may be written into memory, and the pass/fail outcome of a store-conditional. The memory array itself, coherence and snoop traffic are outside the block. Reservations change only through accepted requests and reset.

Each context owns one reservation slot, which holds an address tag and a valid flag. A tag is the address with the granule offset bits dropped. A plain store, or a store-conditional that passes, is a commit. A commit wipes every slot that holds the same tag, whichever context owns it. A store-conditional that fails changes nothing.

Requests come in on a valid/ready stream. A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. Results go out on a second valid/ready stream and appear in the cycle after acceptance. `req_ready` is high whenever the result register is empty or is being drained in the same cycle (`rsp_ready` high). While a result waits with `rsp_ready` low, `req_ready` is low and the result fields hold steady. A requester must keep a request's fields stable until it is accepted.

Top module: `ll_resv_monitor`

## Requirements
- R1: After reset no result is pending, and no context holds a reservation: a store-conditional from any context fails.
- R2: Address bits below the granule size (6 bits, 64-byte granule) are ignored when reservations are stored and compared. Addresses that differ only in those bits match each other.
- R3: A load-linked request arms the requesting context's slot with its address tag. A second load-linked from the same context replaces the tag, so a later store-conditional to the old granule fails.
- R4: A store-conditional passes only when the requesting context's own slot is armed with the same tag. On a pass it reports store-allowed 1 and pass 1. On a fail it reports 0 and 0.
- R5: A plain store always reports store-allowed 1 and pass 0.
- R6: A commit (a plain store or a passing store-conditional) disarms every slot holding the committed tag, in all contexts, including the committer's own slot.
- R7: A failing store-conditional disarms no slot, including other contexts' slots on the same granule.
- R8: Several contexts may hold armed slots on the same granule at once. Arming one context's slot does not disturb another context's slot.
- R9: A plain read leaves every slot unchanged and reports store-allowed 0 and pass 0. A load-linked also reports 0 and 0.
- R10: The result for an accepted request appears with `rsp_valid` high in the following cycle.
- R11: While `rsp_valid` is high and `rsp_ready` is low, the result fields stay stable and `req_ready` is low. The encoding of `req_kind` is 0 for a plain read, 1 for a load-linked, 2 for a plain store and 3 for a store-conditional.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_ctx | input | 2 | Requesting context number |
| req_addr | input | 32 | Physical byte address |
| req_kind | input | 2 | 0 read, 1 load-linked, 2 store, 3 store-conditional |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_store_ok | output | 1 | Store may be written to memory |
| rsp_sc_pass | output | 1 | Store-conditional outcome, 1 = pass |

## Verification
The hardest situation to observe from the ports is a slot's state when no store-conditional tests it. This matters most for a third context whose reservation sits on a granule that another context just failed to write, or that a shared commit just wiped. The stimulus reaches that state with short directed chains. Two or three contexts arm the same granule, one of them fires a failing or passing store-conditional, and each remaining context then probes its own slot with a store-conditional of its own. A long random phase follows. It uses a handful of granules, random low address bits and random result back-pressure, so that overlaps, overwrites and stalls mix freely against a behavioural model.

// File: rtl/llmon_pkg.sv
package llmon_pkg;
  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_LL    = 2'd1,
    KIND_STORE = 2'd2,
    KIND_SC    = 2'd3
  } req_kind_e;
endpackage

// File: rtl/resv_slot.sv
// One reservation slot: armed flag plus granule tag.
module resv_slot #(
  parameter int TAG_W = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic             clr_en,
  input  logic [TAG_W-1:0] req_tag,
  output logic             held,
  output logic             tag_hit
);
  logic [TAG_W-1:0] tag_q;

  assign tag_hit = held && (tag_q == req_tag);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held  <= 1'b0;
      tag_q <= '0;
    end else if (set_en) begin
      held  <= 1'b1;
      tag_q <= req_tag;
    end else if (clr_en && tag_hit) begin
      held <= 1'b0;
    end
  end

  // R3: arming always leaves the slot armed
  p_arm_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> held);
  // R6: a commit on a matching tag disarms the slot
  p_commit_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && tag_hit) |=> !held);
  // R6: arm and commit-clear never coincide on a slot
  p_set_clr_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_en && clr_en));
endmodule

// File: rtl/commit_decide.sv
// Decides store permission, store-conditional outcome and slot updates.
module commit_decide
  import llmon_pkg::*;
#(
  parameter int N_CTX = 4,
  parameter int CTX_W = 2
) (
  input  logic             accept,
  input  req_kind_e        kind,
  input  logic [CTX_W-1:0] ctx,
  input  logic [N_CTX-1:0] hit_vec,
  output logic [N_CTX-1:0] set_vec,
  output logic             clr_all,
  output logic             store_ok,
  output logic             sc_pass
);
  logic own_hit;

  assign own_hit  = hit_vec[ctx];
  assign sc_pass  = (kind == KIND_SC) && own_hit;
  assign store_ok = (kind == KIND_STORE) || sc_pass;
  assign clr_all  = accept && store_ok;

  for (genvar g = 0; g < N_CTX; g++) begin : g_set
    assign set_vec[g] = accept && (kind == KIND_LL) && (ctx == CTX_W'(g));
  end
endmodule

// File: rtl/ll_resv_monitor.sv
module ll_resv_monitor
  import llmon_pkg::*;
#(
  parameter int N_CTX     = 4,
  parameter int CTX_W     = (N_CTX > 1) ? $clog2(N_CTX) : 1,
  parameter int ADDR_W    = 32,
  parameter int GRAN_BITS = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CTX_W-1:0]  req_ctx,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_kind,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_store_ok,
  output logic              rsp_sc_pass
);
  localparam int TAG_W = ADDR_W - GRAN_BITS;

  req_kind_e        kind;
  logic             accept;
  logic [TAG_W-1:0] req_tag;
  logic [N_CTX-1:0] hit_vec, held_vec, set_vec;
  logic             clr_all, store_ok, sc_pass;

  assign kind      = req_kind_e'(req_kind);
  assign req_tag   = req_addr[ADDR_W-1:GRAN_BITS];
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  for (genvar g = 0; g < N_CTX; g++) begin : g_slot
    resv_slot #(.TAG_W(TAG_W)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_en  (set_vec[g]),
      .clr_en  (clr_all),
      .req_tag (req_tag),
      .held    (held_vec[g]),
      .tag_hit (hit_vec[g])
    );
  end

  commit_decide #(.N_CTX(N_CTX), .CTX_W(CTX_W)) u_decide (
    .accept   (accept),
    .kind     (kind),
    .ctx      (req_ctx),
    .hit_vec  (hit_vec),
    .set_vec  (set_vec),
    .clr_all  (clr_all),
    .store_ok (store_ok),
    .sc_pass  (sc_pass)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_store_ok <= 1'b0;
      rsp_sc_pass  <= 1'b0;
    end else if (req_ready) begin
      rsp_valid <= accept;
      if (accept) begin
        rsp_store_ok <= store_ok;
        rsp_sc_pass  <= sc_pass;
      end
    end
  end

  // R10: result one cycle after acceptance
  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);
  // R11: stalled result holds and blocks new requests
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_store_ok) && $stable(rsp_sc_pass)));
  // R4: a pass always carries store permission
  p_pass_ok_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_sc_pass) |-> rsp_store_ok);
  // R5: plain store result
  p_plain_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && kind == KIND_STORE) |=> (rsp_store_ok && !rsp_sc_pass));
  // R7: failing store-conditional leaves all slots alone
  p_fail_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && kind == KIND_SC && !sc_pass) |=> $stable(held_vec));
  // R9: plain read leaves all slots alone and forbids the store
  p_read_inert_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && kind == KIND_READ) |=> ($stable(held_vec) && !rsp_store_ok));
  // R3: at most one slot armed per request
  p_one_arm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(set_vec));
endmodule

// File: tb/ll_resv_monitor_test.sv
`timescale 1ns/1ps
module ll_resv_monitor_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_ctx = '0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_kind = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_store_ok;
  logic        rsp_sc_pass;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;  // 125 MHz

  ll_resv_monitor uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_ctx(req_ctx), .req_addr(req_addr), .req_kind(req_kind),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_store_ok(rsp_store_ok), .rsp_sc_pass(rsp_sc_pass)
  );

  // behavioural reference
  bit          m_armed [4];
  int unsigned m_tag   [4];
  bit          m_valid, m_ok, m_sc;
  string       m_req;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_armed[i]) m_armed[i] = 0;
      m_valid = 0; m_ok = 0; m_sc = 0; m_req = "R1";
    end else begin
      bit rdy, acc, pass, commit;
      int unsigned t;
      rdy = !m_valid || rsp_ready;
      acc = req_valid && rdy;
      t = req_addr >> 6;
      if (acc) begin
        pass = 0; commit = 0;
        case (req_kind)
          2'd1: begin m_armed[req_ctx] = 1; m_tag[req_ctx] = t; m_req = "R3"; end
          2'd2: begin commit = 1; m_req = "R5"; end
          2'd3: begin
            pass = m_armed[req_ctx] && (m_tag[req_ctx] == t);
            commit = pass; m_req = "R4";
          end
          default: m_req = "R9";
        endcase
        if (commit)
          foreach (m_armed[i]) if (m_armed[i] && m_tag[i] == t) m_armed[i] = 0;
        m_valid = 1; m_ok = commit; m_sc = pass;
      end else if (rdy) begin
        m_valid = 0;
      end
    end
  end

  task automatic chk(input bit act, input bit exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  // compare on every clock, away from the edge
  always @(negedge clk) begin
    if (!done) begin
      chk(rsp_valid, rst_n ? m_valid : 1'b0, rst_n ? "R10" : "R1", "rsp_valid");
      if (rst_n) begin
        chk(req_ready, !m_valid || rsp_ready, "R11", "req_ready");
        if (m_valid) begin
          chk(rsp_store_ok, m_ok, m_req, "store_ok");
          chk(rsp_sc_pass, m_sc, m_req, "sc_pass");
        end
      end
    end
  end

  // directed request with rsp_ready held high; result checked one cycle later
  task automatic req(input logic [1:0] k, input logic [1:0] c, input logic [31:0] a,
                     input bit eok, input bit esc, input string tag);
    @(negedge clk); #1;
    req_valid = 1; req_kind = k; req_ctx = c; req_addr = a;
    @(posedge clk); #1;
    req_valid = 0;
    @(negedge clk);
    chk(rsp_valid, 1'b1, "R10", {tag, " result present"});
    chk(rsp_store_ok, eok, tag, "directed store_ok");
    chk(rsp_sc_pass, esc, tag, "directed sc_pass");
  endtask

  localparam logic [1:0] RD = 2'd0, LL = 2'd1, ST = 2'd2, SC = 2'd3;

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1: nothing armed after reset
    for (int c = 0; c < 4; c++) req(SC, c[1:0], 32'h1000, 0, 0, "R1");
    // R4: own reservation passes
    req(LL, 0, 32'h1000, 0, 0, "R9");
    req(SC, 0, 32'h1000, 1, 1, "R4");
    req(SC, 0, 32'h1000, 0, 0, "R6");
    // R6: plain store wipes every context on the granule
    req(LL, 0, 32'h2000, 0, 0, "R3");
    req(LL, 1, 32'h2000, 0, 0, "R3");
    req(ST, 2, 32'h2010, 1, 0, "R5");
    req(SC, 0, 32'h2000, 0, 0, "R6");
    req(SC, 1, 32'h2000, 0, 0, "R6");
    // R7: failed conditional keeps others; R2 masking; R6 shared wipe
    req(LL, 0, 32'h3000, 0, 0, "R3");
    req(LL, 1, 32'h3000, 0, 0, "R3");
    req(SC, 2, 32'h3000, 0, 0, "R7");
    req(SC, 1, 32'h5000, 0, 0, "R7");
    req(SC, 0, 32'h3004, 1, 1, "R2");
    req(SC, 1, 32'h3000, 0, 0, "R6");
    // R8: shared granule, arming one context leaves the other intact
    req(LL, 1, 32'h4000, 0, 0, "R8");
    req(LL, 2, 32'h4000, 0, 0, "R8");
    req(RD, 3, 32'h4000, 0, 0, "R9");
    req(SC, 1, 32'h4000, 1, 1, "R8");
    req(LL, 1, 32'h4000, 0, 0, "R8");
    req(LL, 2, 32'h4000, 0, 0, "R8");
    req(SC, 2, 32'h4000, 1, 1, "R8");
    // R3: second load-linked replaces the first
    req(LL, 0, 32'h6000, 0, 0, "R3");
    req(LL, 0, 32'h7000, 0, 0, "R3");
    req(SC, 0, 32'h6000, 0, 0, "R3");
    req(SC, 0, 32'h7000, 1, 1, "R3");
    // R2: low bits ignored, neighbouring granule differs
    req(LL, 3, 32'h803F, 0, 0, "R2");
    req(SC, 3, 32'h8040, 0, 0, "R2");
    req(SC, 3, 32'h8000, 1, 1, "R2");
    // random mix with back-pressure (R10, R11), model-checked each clock
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk); #1;
      rsp_ready = ($urandom % 4) != 0;
      if (($urandom % 5) == 0) continue;
      req_valid = 1;
      req_kind  = 2'($urandom % 4);
      req_ctx   = 2'($urandom % 4);
      req_addr  = (32'h1000 + 32'h40 * ($urandom % 3)) | ($urandom % 64);
      #1;
      while (!req_ready) begin
        @(negedge clk); #1;
        rsp_ready = ($urandom % 4) != 0;
        #1;
      end
      @(posedge clk); #1;
      req_valid = 0;
    end
    @(negedge clk); #1 rsp_ready = 1;
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL R10 watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule